// File: doc/BRIEF.md
# Phase-Controlled Thyristor Firing Generator

This block turns a digitised AC-line polarity level into gate firing pulses for thyristor rectifiers, inverters and AC regulators. Every time the filtered polarity changes, a half-cycle begins. The block counts a commanded number of clock ticks from that zero crossing and then raises a pulse of programmable length. The pulse goes to the positive-half channel after a rising crossing and to the negative-half channel after a falling crossing. A protection inhibit input suppresses all firing.

The polarity input is asynchronous. It passes through a synchroniser chain and a run-length debounce filter before crossings are detected. The delay word and the pulse-width word are captured at each accepted crossing, so they can be changed freely at any point in a half-cycle. The comparator, the gate drivers and the high-voltage stages lie outside this block.

Top module: `thyristor_fire_gen`

## Requirements
- R1: After reset both gate outputs are low, and no pulse is issued until a first crossing has been accepted.
- R2: The polarity input is synchronised through SYNC_LEN flops. A new level is accepted only after it has been seen on DEB_LEN consecutive synchronised samples. Shorter excursions produce no crossing.
- R3: An accepted low-to-high change is a positive crossing and drives only `gate_pos_o`. An accepted high-to-low change is a negative crossing and drives only `gate_neg_o`. The two outputs are never high together.
- R4: With a settled line, a delay word D and a non-zero width, the gate first reads high after the (SYNC_LEN+DEB_LEN+D+2)-th rising clock edge that samples the new polarity level.
- R5: The delay word is captured at each accepted crossing. A change made later in the half-cycle applies only from the next crossing.
- R6: The pulse stays high for exactly W clocks, where W is the width word captured at the crossing. W = 0 gives no pulse.
- R7: A pulse still high when the next crossing is accepted drops on the clock edge that registers that crossing.
- R8: A half-cycle whose length in clocks between accepted crossings is L gets a pulse only if D+2 <= L. Otherwise it gets no pulse at all.
- R9: While `inhibit_i` is sampled high, both outputs are low from the next clock edge on.
- R10: After inhibit is released, no pulse fires until a crossing has been accepted with inhibit low. That half-cycle then fires normally.
- R11: The tick counter saturates at its all-ones value. At most one pulse is issued per half-cycle, even when the half-cycle outlasts the counter range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_pol_i | input | 1 | Asynchronous line polarity, 1 = positive half |
| delay_i | input | DELAY_W | Firing delay in clock ticks after the crossing |
| width_i | input | WIDTH_W | Firing pulse length in clock ticks |
| inhibit_i | input | 1 | Protection inhibit, 1 blocks all firing |
| gate_pos_o | output | 1 | Positive-half firing pulse |
| gate_neg_o | output | 1 | Negative-half firing pulse |

## Verification
The bench builds the block with SYNC_LEN = 2, DEB_LEN = 4, DELAY_W = 12 and WIDTH_W = 8. A four-sample debounce makes a three-clock glitch just short of acceptance. The 12-bit delay lets a 5000-clock half-cycle run the tick counter into saturation with a maximum delay, which exercises the one-pulse-per-half rule. Half-cycles of 200 clocks place delays of 198 and 199 on either side of the no-fire boundary. The same half-cycle length leaves room to cut a long pulse at the following crossing and to drop inhibit in the middle of a pulse.

// File: rtl/tfg_pkg.sv
package tfg_pkg;
  typedef struct packed {
    logic valid;
    logic positive;
  } crossing_t;
endpackage

// File: rtl/pol_sync.sv
module pol_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] stage_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage_q[0] <= 1'b0;
        else     stage_q[0] <= async_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage_q[i] <= 1'b0;
        else     stage_q[i] <= stage_q[i-1];
      end
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/pol_debounce.sv
module pol_debounce
  import tfg_pkg::*;
#(
  parameter int DEB_LEN = 4
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      level_i,
  output crossing_t crossing_o
);
  localparam int RUN_W = (DEB_LEN > 1) ? $clog2(DEB_LEN) : 1;
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(DEB_LEN - 1);

  logic             filt_q;
  logic [RUN_W-1:0] run_q;
  logic             rise_q, fall_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      filt_q <= 1'b0;
      run_q  <= '0;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else begin
      rise_q <= 1'b0;
      fall_q <= 1'b0;
      if (level_i != filt_q) begin
        if (run_q == RUN_LAST) begin
          filt_q <= level_i;
          run_q  <= '0;
          rise_q <= level_i;
          fall_q <= ~level_i;
        end else begin
          run_q <= run_q + 1'b1;
        end
      end else begin
        run_q <= '0;
      end
    end
  end

  assign crossing_o.valid    = rise_q | fall_q;
  assign crossing_o.positive = rise_q;

  AST_EDGE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(rise_q && fall_q)); // R2
  AST_RISE_FROM_HIGH: assert property (@(posedge clk) disable iff (rst)
    rise_q |-> $past(level_i)); // R2
  AST_FALL_FROM_LOW: assert property (@(posedge clk) disable iff (rst)
    fall_q |-> !$past(level_i)); // R2
endmodule

// File: rtl/fire_timer.sv
module fire_timer
  import tfg_pkg::*;
#(
  parameter int DELAY_W = 12,
  parameter int WIDTH_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  crossing_t          crossing_i,
  input  logic [DELAY_W-1:0] delay_i,
  input  logic [WIDTH_W-1:0] width_i,
  input  logic               inhibit_i,
  output logic               gate_pos_o,
  output logic               gate_neg_o
);
  localparam logic [DELAY_W-1:0] CNT_MAX = '1;
  localparam logic [WIDTH_W-1:0] WID_ONE = WIDTH_W'(1);

  logic [DELAY_W-1:0] cnt_q, dly_q;
  logic [WIDTH_W-1:0] wid_q, wcnt_q;
  logic               half_pos_q, fired_q, blocked_q;
  logic               gp_q, gn_q;
  logic               fire_now, gate_on;

  assign gate_on  = gp_q | gn_q;
  assign fire_now = !fired_q && !blocked_q && (cnt_q == dly_q) && (wid_q != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q      <= '0;
      dly_q      <= '0;
      wid_q      <= '0;
      wcnt_q     <= '0;
      half_pos_q <= 1'b0;
      fired_q    <= 1'b0;
      blocked_q  <= 1'b1;
      gp_q       <= 1'b0;
      gn_q       <= 1'b0;
    end else if (crossing_i.valid) begin
      cnt_q      <= '0;
      dly_q      <= delay_i;
      wid_q      <= width_i;
      wcnt_q     <= '0;
      half_pos_q <= crossing_i.positive;
      fired_q    <= 1'b0;
      blocked_q  <= inhibit_i;
      gp_q       <= 1'b0;
      gn_q       <= 1'b0;
    end else begin
      if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
      if (inhibit_i) begin
        blocked_q <= 1'b1;
        gp_q      <= 1'b0;
        gn_q      <= 1'b0;
      end else if (fire_now) begin
        gp_q    <= half_pos_q;
        gn_q    <= ~half_pos_q;
        fired_q <= 1'b1;
        wcnt_q  <= '0;
      end else if (gate_on) begin
        if (wcnt_q == wid_q - WID_ONE) begin
          gp_q <= 1'b0;
          gn_q <= 1'b0;
        end else begin
          wcnt_q <= wcnt_q + 1'b1;
        end
      end
    end
  end

  assign gate_pos_o = gp_q;
  assign gate_neg_o = gn_q;

  AST_ONE_CHANNEL: assert property (@(posedge clk) disable iff (rst)
    !(gp_q && gn_q)); // R3
  AST_INHIBIT_CLEARS: assert property (@(posedge clk) disable iff (rst)
    inhibit_i |=> !(gp_q || gn_q)); // R9
  AST_CROSSING_CUTS: assert property (@(posedge clk) disable iff (rst)
    crossing_i.valid |=> !(gp_q || gn_q)); // R7
  AST_RESUME_AFTER_CROSSING: assert property (@(posedge clk) disable iff (rst)
    $rose(gp_q || gn_q) |-> !$past(blocked_q)); // R10
  AST_SINGLE_FIRE: assert property (@(posedge clk) disable iff (rst)
    $rose(gp_q || gn_q) |-> !$past(fired_q)); // R11
endmodule

// File: rtl/thyristor_fire_gen.sv
module thyristor_fire_gen
  import tfg_pkg::*;
#(
  parameter int SYNC_LEN = 2,
  parameter int DEB_LEN  = 4,
  parameter int DELAY_W  = 12,
  parameter int WIDTH_W  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               line_pol_i,
  input  logic [DELAY_W-1:0] delay_i,
  input  logic [WIDTH_W-1:0] width_i,
  input  logic               inhibit_i,
  output logic               gate_pos_o,
  output logic               gate_neg_o
);
  logic      pol_sync_w;
  crossing_t crossing_w;

  pol_sync #(.STAGES(SYNC_LEN)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i (line_pol_i),
    .sync_o  (pol_sync_w)
  );

  pol_debounce #(.DEB_LEN(DEB_LEN)) u_deb (
    .clk        (clk),
    .rst        (rst),
    .level_i    (pol_sync_w),
    .crossing_o (crossing_w)
  );

  fire_timer #(.DELAY_W(DELAY_W), .WIDTH_W(WIDTH_W)) u_timer (
    .clk        (clk),
    .rst        (rst),
    .crossing_i (crossing_w),
    .delay_i    (delay_i),
    .width_i    (width_i),
    .inhibit_i  (inhibit_i),
    .gate_pos_o (gate_pos_o),
    .gate_neg_o (gate_neg_o)
  );
endmodule

// File: tb/thyristor_fire_gen_bench.sv
module thyristor_fire_gen_bench;
  localparam int SYNC_LEN = 2;
  localparam int DEB_LEN  = 4;
  localparam int DELAY_W  = 12;
  localparam int WIDTH_W  = 8;
  localparam int MAXC     = (1 << DELAY_W) - 1;
  localparam int LAT      = SYNC_LEN + DEB_LEN + 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic line_r = 1'b0;
  logic [DELAY_W-1:0] delay_r = '0;
  logic [WIDTH_W-1:0] width_r = '0;
  logic inhibit_r = 1'b0;
  logic gate_pos, gate_neg;

  always #2 clk = ~clk;

  thyristor_fire_gen #(.SYNC_LEN(SYNC_LEN), .DEB_LEN(DEB_LEN),
                       .DELAY_W(DELAY_W), .WIDTH_W(WIDTH_W)) u_thyristor_fire_gen (
    .clk(clk), .rst(rst), .line_pol_i(line_r), .delay_i(delay_r),
    .width_i(width_r), .inhibit_i(inhibit_r),
    .gate_pos_o(gate_pos), .gate_neg_o(gate_neg));

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  string cur_req = "R1";

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int q[$];
  int m_filt, m_run, m_ev, m_ev_prev;
  int m_since, m_d, m_w, m_half, m_left, m_fired, m_block;

  always @(posedge clk) begin
    if (rst) begin
      q = {};
      for (int i = 0; i < SYNC_LEN; i++) q.push_back(0);
      m_filt = 0; m_run = 0; m_ev = 0; m_ev_prev = 0;
      m_since = 0; m_d = 0; m_w = 0; m_half = 0; m_left = 0;
      m_fired = 0; m_block = 1;
    end else begin
      int last;
      bit fire;
      last = q.pop_back();
      q.push_front(int'(line_r));
      m_ev = 0;
      if (last != m_filt) begin
        if (m_run == DEB_LEN - 1) begin
          m_filt = last; m_run = 0; m_ev = (last != 0) ? 1 : 2;
        end else m_run++;
      end else m_run = 0;
      if (m_ev_prev != 0) begin
        m_since = 0; m_d = int'(delay_r); m_w = int'(width_r);
        m_half = (m_ev_prev == 1) ? 1 : 0; m_left = 0; m_fired = 0;
        m_block = int'(inhibit_r);
      end else begin
        fire = (m_fired == 0) && (m_block == 0) && (m_since == m_d) && (m_w != 0);
        if (inhibit_r) begin
          m_block = 1; m_left = 0;
        end else if (fire) begin
          m_left = m_w; m_fired = 1;
        end else if (m_left > 0) m_left--;
        if (m_since < MAXC) m_since++;
      end
      m_ev_prev = m_ev;
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      int ep, en;
      ep = (m_left > 0 && m_half == 1) ? 1 : 0;
      en = (m_left > 0 && m_half == 0) ? 1 : 0;
      chk((int'(gate_pos) == ep) && (int'(gate_neg) == en), cur_req,
          int'({gate_pos, gate_neg}), (ep << 1) | en);
    end
  end

  // per-half observation
  int hp, hn, hip, hin, first;
  logic prev_p = 1'b0, prev_n = 1'b0;

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_half(input logic lvl, input int len);
    line_r = lvl;
    hp = 0; hn = 0; hip = 0; hin = 0; first = 0;
    for (int k = 1; k <= len; k++) begin
      @(negedge clk);
      if (gate_pos && !prev_p) begin hp++; if (first == 0) first = k; end
      if (gate_neg && !prev_n) begin hn++; if (first == 0) first = k; end
      if (gate_pos) hip++;
      if (gate_neg) hin++;
      prev_p = gate_pos; prev_n = gate_neg;
    end
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    finish_run();
  end

  initial begin
    int sum;
    delay_r = 12'd50; width_r = 8'd20;
    hold(5);
    rst = 1'b0;
    @(negedge clk);
    cur_req = "R1";
    chk(!gate_pos && !gate_neg, "R1", int'({gate_pos, gate_neg}), 0);
    run_half(1'b0, 100);
    chk(hp == 0 && hn == 0, "R1", hp + hn, 0);

    cur_req = "R4";
    run_half(1'b1, 200);
    run_half(1'b0, 200);
    chk(first == LAT + 50, "R4", first, LAT + 50);
    chk(hn == 1 && hp == 0, "R3", hn * 10 + hp, 10);
    run_half(1'b1, 200);
    chk(first == LAT + 50, "R4", first, LAT + 50);
    chk(hp == 1 && hn == 0, "R3", hp * 10 + hn, 10);

    cur_req = "R5";
    fork
      run_half(1'b0, 200);
      begin hold(20); delay_r = 12'd120; end
    join
    chk(first == LAT + 50, "R5", first, LAT + 50);
    run_half(1'b1, 200);
    chk(first == LAT + 120, "R5", first, LAT + 120);

    cur_req = "R6";
    delay_r = 12'd30; width_r = 8'd0;
    run_half(1'b0, 200);
    chk(hn == 0, "R6", hn, 0);
    width_r = 8'd7;
    run_half(1'b1, 200);
    chk(hip == 7 && hp == 1, "R6", hip, 7);

    cur_req = "R7";
    delay_r = 12'd150; width_r = 8'd200;
    run_half(1'b0, 200);
    run_half(1'b1, 200);
    chk(hin == SYNC_LEN + DEB_LEN, "R7", hin, SYNC_LEN + DEB_LEN);
    chk(hp == 1, "R7", hp, 1);

    cur_req = "R8";
    delay_r = 12'd199; width_r = 8'd10;
    run_half(1'b0, 200);
    run_half(1'b1, 200); sum = hp + hn;
    run_half(1'b0, 200); sum += hp + hn;
    chk(sum == 0, "R8", sum, 0);
    delay_r = 12'd198;
    run_half(1'b1, 200);
    run_half(1'b0, 200); sum = hp + hn;
    run_half(1'b1, 200); sum += hp + hn;
    chk(sum == 2, "R8", sum, 2);

    cur_req = "R2";
    delay_r = 12'd50; width_r = 8'd20;
    run_half(1'b0, 200);
    fork
      run_half(1'b1, 200);
      begin hold(100); line_r = 1'b0; hold(DEB_LEN - 1); line_r = 1'b1; end
    join
    chk(hp == 1 && hn == 0, "R2", hp * 10 + hn, 10);

    cur_req = "R9";
    delay_r = 12'd10; width_r = 8'd100;
    run_half(1'b0, 200);
    fork
      run_half(1'b1, 200);
      begin
        hold(40); inhibit_r = 1'b1;
        @(negedge clk);
        chk(!gate_pos, "R9", int'(gate_pos), 0);
        hold(8); inhibit_r = 1'b0;
      end
    join
    chk(hp == 1, "R10", hp, 1);
    cur_req = "R10";
    run_half(1'b0, 200);
    chk(hn == 1 && first == LAT + 10, "R10", first, LAT + 10);
    inhibit_r = 1'b1;
    run_half(1'b1, 200);
    chk(hp == 0, "R9", hp, 0);
    inhibit_r = 1'b0;
    run_half(1'b0, 200);
    chk(hn == 1, "R10", hn, 1);

    cur_req = "R11";
    delay_r = 12'(MAXC); width_r = 8'd5;
    run_half(1'b1, 200);
    run_half(1'b0, 5000);
    chk(hn == 1, "R11", hn, 1);
    chk(hin == 5, "R11", hin, 5);
    chk(first == LAT + MAXC, "R11", first, LAT + MAXC);

    hold(5);
    finish_run();
  end
endmodule